// File: doc/BRIEF.md
# DMA Channel Bus Address and Transfer Count Generator

This block holds the address and count state of one DMA channel and turns it into a 32-bit physical bus address for every transfer cycle. A 16-bit current address counter is combined with two 8-bit page registers: a low page that supplies the middle address byte and a high page that supplies the top byte. A 16-bit current count counter tracks how many transfers are left and flags terminal count when the last transfer has been made.

A build-time parameter picks byte transfers or 16-bit word transfers. In word mode the counter addresses words, so it is shifted up one bit on the bus and the lowest bit of the low page is unused. A channel normally stays inside one page: the address counter wraps and the page stays fixed. Once the high page register has been written (the last step of address setup), the channel enters extended mode and a carry out of the address counter moves on to the next page. Writing the low page leaves extended mode again.

When terminal count is reached, a channel with auto-initialise set reloads its address and count from the values last written and keeps running. Without auto-initialise, it stops and ignores further advance strobes until a new count is loaded.

Top module: `dma_addr_gen`

## Requirements
- R1: In byte mode (MODE = XFER_BYTE) the bus address is high page in bits [31:24], low page in bits [23:16] and the current address in bits [15:0].
- R2: In word mode (MODE = XFER_WORD) the bus address is high page in [31:24], low page bits [7:1] in [23:17], the current address in [16:1] and 0 in bit 0. Low page bit 0 has no effect.
- R3: Outside extended mode, an advance at current address 0xFFFF wraps it to 0x0000 and leaves both page registers unchanged.
- R4: In extended mode, an advance at current address 0xFFFF wraps it and increments the combined page. The combined page is {high, low} in byte mode and {high, low[7:1]} in word mode, so the bus address moves on by one transfer size across the page boundary.
- R5: Reset clears extended mode. A high-page write enters extended mode. A low-page write without a high-page write in the same cycle leaves it.
- R6: Each accepted advance decrements the current count by one. The advance that finds the count at 0x0000 asserts term_cnt for exactly the following cycle, so a loaded count N gives term_cnt after N+1 advances.
- R7: residual shows the current count. remain_bytes shows (residual+1) modulo 2^16, doubled in word mode. After a completed transfer with no auto-initialise, residual is 0xFFFF and remain_bytes is 0.
- R8: Without auto-initialise, terminal count sets done. While done is set, advance strobes change neither the address nor the count. A count load clears done.
- R9: With auto-initialise, terminal count reloads the current address and count from the last loaded values and done stays low.
- R10: When terminal count with auto-initialise falls in the same cycle as an address carry in extended mode, the reload wins and the page registers are not incremented.
- R11: After reset the bus address, the count, term_cnt and done are all zero.
- R12: In a cycle that carries any load strobe, advance is ignored. Each load takes effect on the next clock edge and sets both the base copy and the current copy of its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_ld | input | 1 | Load base and current address from addr_in |
| addr_in | input | 16 | Address load value |
| cnt_ld | input | 1 | Load base and current count from cnt_in, clears done |
| cnt_in | input | 16 | Count load value (transfers minus one) |
| pglo_ld | input | 1 | Write low page register, leaves extended mode |
| pglo_in | input | 8 | Low page value |
| pghi_ld | input | 1 | Write high page register, enters extended mode |
| pghi_in | input | 8 | High page value |
| auto_init | input | 1 | Reload at terminal count instead of stopping |
| advance | input | 1 | One transfer performed this cycle |
| bus_addr | output | 32 | Physical bus address of the current transfer |
| term_cnt | output | 1 | One-cycle terminal count pulse |
| done | output | 1 | Channel stopped at terminal count |
| residual | output | 16 | Current count value |
| remain_bytes | output | 17 | Bytes still to transfer |

## Verification
Two functions can land in the same cycle: the terminal-count handling and the page carry of the address counter. To make them meet, the bench sets extended mode, loads address 0xFFFF and count 0, and issues one advance, once with auto-initialise set and once with it clear. With auto-initialise the bus address must come back to the loaded address in the same page. Without it the address must cross into the next page and done must rise. Both byte and word instances are judged against an independent byte-address model. A second meeting point is a load strobe together with an advance, where the bench expects the load alone to take effect.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  parameter int unsigned CTR_W = 16;
  parameter int unsigned PG_W  = 8;
  localparam int unsigned BUS_W = CTR_W + 2*PG_W;
  localparam int unsigned REM_W = CTR_W + 1;

  typedef enum logic {XFER_BYTE = 1'b0, XFER_WORD = 1'b1} xfer_mode_e;

  // Bus address from counter and page registers.
  function automatic logic [BUS_W-1:0] compose_bus(
    input xfer_mode_e mode, input logic [CTR_W-1:0] a,
    input logic [PG_W-1:0] lo, input logic [PG_W-1:0] hi);
    if (mode == XFER_WORD) return {hi, lo[PG_W-1:1], a, 1'b0};
    return {hi, lo, a};
  endfunction

  // Combined page {hi,lo} after one carry from the address counter.
  function automatic logic [2*PG_W-1:0] bump_page(
    input xfer_mode_e mode, input logic [PG_W-1:0] lo, input logic [PG_W-1:0] hi);
    logic [2*PG_W-2:0] wpg;
    if (mode == XFER_WORD) begin
      wpg = {hi, lo[PG_W-1:1]} + (2*PG_W-1)'(1);
      return {wpg, lo[0]};
    end
    return {hi, lo} + (2*PG_W)'(1);
  endfunction

  // Remaining bytes from a count register holding transfers-minus-one.
  function automatic logic [REM_W-1:0] remain_of(
    input xfer_mode_e mode, input logic [CTR_W-1:0] cnt);
    logic [CTR_W-1:0] n;
    n = cnt + CTR_W'(1);
    if (mode == XFER_WORD) return {n, 1'b0};
    return {1'b0, n};
  endfunction
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr
  import dma_ag_pkg::*;
#(
  parameter xfer_mode_e MODE = XFER_BYTE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_ld,
  input  logic [CTR_W-1:0] addr_in,
  input  logic             pglo_ld,
  input  logic [PG_W-1:0]  pglo_in,
  input  logic             pghi_ld,
  input  logic [PG_W-1:0]  pghi_in,
  input  logic             step,
  input  logic             reload,
  output logic [CTR_W-1:0] cur_addr,
  output logic [PG_W-1:0]  page_lo,
  output logic [PG_W-1:0]  page_hi,
  output logic             ext_en,
  output logic             carry_evt,
  output logic             page_inc
);
  logic [CTR_W-1:0]  base_addr;
  logic [2*PG_W-1:0] next_page;

  assign carry_evt = step && (cur_addr == {CTR_W{1'b1}});
  assign page_inc  = carry_evt && ext_en && !reload;
  assign next_page = bump_page(MODE, page_lo, page_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      cur_addr  <= '0;
    end else if (addr_ld) begin
      base_addr <= addr_in;
      cur_addr  <= addr_in;
    end else if (step) begin
      cur_addr  <= reload ? base_addr : cur_addr + CTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_lo <= '0;
      page_hi <= '0;
      ext_en  <= 1'b0;
    end else begin
      if (page_inc) begin
        page_hi <= next_page[2*PG_W-1:PG_W];
        page_lo <= next_page[PG_W-1:0];
      end
      if (pglo_ld) page_lo <= pglo_in;
      if (pghi_ld) page_hi <= pghi_in;
      if (pghi_ld)      ext_en <= 1'b1;
      else if (pglo_ld) ext_en <= 1'b0;
    end
  end

  // R3: no page movement on a carry outside extended mode
  a_r3_wrap_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_evt && !ext_en && !pglo_ld && !pghi_ld) |=>
      ($stable(page_lo) && $stable(page_hi) && cur_addr == '0));

  // R4: carry in extended mode advances the combined page
  a_r4_page_carry: assert property (@(posedge clk) disable iff (!rst_n)
    page_inc |=> ({page_hi, page_lo} == $past(next_page)));

  // R5: mode flag follows page writes
  a_r5_hi_sets_ext: assert property (@(posedge clk) disable iff (!rst_n)
    pghi_ld |=> ext_en);
  a_r5_lo_clears_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (pglo_ld && !pghi_ld) |=> !ext_en);

  // R10: reload at terminal count keeps the page
  a_r10_reload_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
    (step && reload) |=> ($stable(page_lo) && $stable(page_hi)));
endmodule

// File: rtl/dma_cnt_ctr.sv
module dma_cnt_ctr
  import dma_ag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_ld,
  input  logic [CTR_W-1:0] cnt_in,
  input  logic             step,
  input  logic             auto_init,
  output logic [CTR_W-1:0] cur_cnt,
  output logic             term_cnt,
  output logic             done,
  output logic             underflow_evt,
  output logic             reload
);
  logic [CTR_W-1:0] base_cnt;

  assign underflow_evt = step && (cur_cnt == '0);
  assign reload        = underflow_evt && auto_init;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_cnt <= '0;
      cur_cnt  <= '0;
      done     <= 1'b0;
      term_cnt <= 1'b0;
    end else begin
      term_cnt <= underflow_evt;
      if (cnt_ld) begin
        base_cnt <= cnt_in;
        cur_cnt  <= cnt_in;
        done     <= 1'b0;
      end else if (underflow_evt) begin
        cur_cnt  <= auto_init ? base_cnt : {CTR_W{1'b1}};
        done     <= !auto_init;
      end else if (step) begin
        cur_cnt  <= cur_cnt - CTR_W'(1);
      end
    end
  end

  // R6: terminal count pulse only after an underflowing step
  a_r6_tc_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_cnt) |-> $past(underflow_evt));
  a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !underflow_evt) |=> (cur_cnt == $past(cur_cnt) - CTR_W'(1)));

  // R7: a stopped channel shows all-ones residual
  a_r7_done_residual: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cur_cnt == {CTR_W{1'b1}}));

  // R9: auto-initialise never stops the channel
  a_r9_autoinit_runs: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !done);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_ag_pkg::*;
#(
  parameter xfer_mode_e MODE = XFER_BYTE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_ld,
  input  logic [CTR_W-1:0] addr_in,
  input  logic             cnt_ld,
  input  logic [CTR_W-1:0] cnt_in,
  input  logic             pglo_ld,
  input  logic [PG_W-1:0]  pglo_in,
  input  logic             pghi_ld,
  input  logic [PG_W-1:0]  pghi_in,
  input  logic             auto_init,
  input  logic             advance,
  output logic [BUS_W-1:0] bus_addr,
  output logic             term_cnt,
  output logic             done,
  output logic [CTR_W-1:0] residual,
  output logic [REM_W-1:0] remain_bytes
);
  logic             any_ld;
  logic             step;
  logic             reload;
  logic             underflow_evt;
  logic             carry_evt;
  logic             page_inc;
  logic             ext_en;
  logic [CTR_W-1:0] cur_addr;
  logic [PG_W-1:0]  page_lo;
  logic [PG_W-1:0]  page_hi;

  assign any_ld = addr_ld || cnt_ld || pglo_ld || pghi_ld;
  assign step   = advance && !done && !any_ld;

  dma_cnt_ctr i_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt_ld        (cnt_ld),
    .cnt_in        (cnt_in),
    .step          (step),
    .auto_init     (auto_init),
    .cur_cnt       (residual),
    .term_cnt      (term_cnt),
    .done          (done),
    .underflow_evt (underflow_evt),
    .reload        (reload)
  );

  dma_addr_ctr #(.MODE(MODE)) i_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_ld   (addr_ld),
    .addr_in   (addr_in),
    .pglo_ld   (pglo_ld),
    .pglo_in   (pglo_in),
    .pghi_ld   (pghi_ld),
    .pghi_in   (pghi_in),
    .step      (step),
    .reload    (reload),
    .cur_addr  (cur_addr),
    .page_lo   (page_lo),
    .page_hi   (page_hi),
    .ext_en    (ext_en),
    .carry_evt (carry_evt),
    .page_inc  (page_inc)
  );

  assign bus_addr     = compose_bus(MODE, cur_addr, page_lo, page_hi);
  assign remain_bytes = remain_of(MODE, residual);

  // R8: a stopped channel does not move
  a_r8_done_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !any_ld) |=> ($stable(bus_addr) && $stable(residual)));

  // R12: a load cycle never advances the count
  a_r12_load_blocks_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && any_ld && !cnt_ld) |=> $stable(residual));

  // R10: carry and reload together leave the page untouched
  a_r10_no_bump_on_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_evt && underflow_evt && auto_init) |-> !page_inc);

  // R2: word mode bus address is always even
  generate
    if (MODE == XFER_WORD) begin : g_word_chk
      a_r2_word_even: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr[0]);
    end
  endgenerate
endmodule

// File: tb/test_dma_addr_gen.sv
module test_dma_addr_gen;
  import dma_ag_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        addr_ld = 0, cnt_ld = 0, pglo_ld = 0, pghi_ld = 0;
  logic        auto_init = 0, advance = 0;
  logic [15:0] addr_in = 0, cnt_in = 0;
  logic [7:0]  pglo_in = 0, pghi_in = 0;

  logic [31:0] bus_b, bus_w;
  logic        tc_b, tc_w, done_b, done_w;
  logic [15:0] res_b, res_w;
  logic [16:0] rem_b, rem_w;

  dma_addr_gen #(.MODE(XFER_BYTE)) i_dma_addr_gen (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
    .cnt_ld(cnt_ld), .cnt_in(cnt_in), .pglo_ld(pglo_ld), .pglo_in(pglo_in),
    .pghi_ld(pghi_ld), .pghi_in(pghi_in), .auto_init(auto_init), .advance(advance),
    .bus_addr(bus_b), .term_cnt(tc_b), .done(done_b), .residual(res_b),
    .remain_bytes(rem_b));

  dma_addr_gen #(.MODE(XFER_WORD)) i_dma_addr_gen_w (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
    .cnt_ld(cnt_ld), .cnt_in(cnt_in), .pglo_ld(pglo_ld), .pglo_in(pglo_in),
    .pghi_ld(pghi_ld), .pghi_in(pghi_in), .auto_init(auto_init), .advance(advance),
    .bus_addr(bus_w), .term_cnt(tc_w), .done(done_w), .residual(res_w),
    .remain_bytes(rem_w));

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Reference model in byte-address terms, index 0 = byte, 1 = word.
  logic [31:0] ea [2];
  logic [31:0] boff [2];
  bit          ext = 0;
  logic [15:0] cnt = 0, bcnt = 0;
  bit          mdone = 0, mtc = 0;

  function automatic logic [31:0] pmask(input int m);
    return (m == 1) ? 32'h0001_FFFE : 32'h0000_FFFF;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int m = 0; m < 2; m++) begin
      logic [15:0] n1;
      n1 = cnt + 16'd1;
      chk(tag, m ? "word bus_addr" : "byte bus_addr", m ? bus_w : bus_b, ea[m]);
      chk(tag, "term_cnt", {31'b0, m ? tc_w : tc_b}, {31'b0, mtc});
      chk(tag, "done", {31'b0, m ? done_w : done_b}, {31'b0, mdone});
      chk(tag, "residual", {16'b0, m ? res_w : res_b}, {16'b0, cnt});
      chk(tag, "remain_bytes", {15'b0, m ? rem_w : rem_b}, {15'b0, n1} << m);
    end
  endtask

  task automatic cyc(input string tag, input bit la, input logic [15:0] av,
                     input bit lc, input logic [15:0] cv, input bit ll,
                     input logic [7:0] lv, input bit lh, input logic [7:0] hv,
                     input bit adv, input bit ai);
    bit step, und;
    addr_ld = la; addr_in = av; cnt_ld = lc; cnt_in = cv;
    pglo_ld = ll; pglo_in = lv; pghi_ld = lh; pghi_in = hv;
    advance = adv; auto_init = ai;
    step = adv && !mdone && !(la || lc || ll || lh);
    und  = step && (cnt == 16'd0);
    mtc  = und;
    for (int m = 0; m < 2; m++) begin
      logic [31:0] inc;
      inc = 32'd1 << m;
      if (step) begin
        if (und && ai)  ea[m] = (ea[m] & ~pmask(m)) | boff[m];
        else if (ext)   ea[m] = ea[m] + inc;
        else            ea[m] = (ea[m] & ~pmask(m)) | ((ea[m] + inc) & pmask(m));
      end
      if (la) begin
        boff[m] = {16'b0, av} << m;
        ea[m]   = (ea[m] & ~pmask(m)) | boff[m];
      end
      if (ll) begin
        if (m == 1) ea[m][23:17] = lv[7:1];
        else        ea[m][23:16] = lv;
      end
      if (lh) ea[m][31:24] = hv;
    end
    if (ll) ext = 0;
    if (lh) ext = 1;
    if (step) begin
      if (und) begin
        if (ai) cnt = bcnt;
        else begin cnt = 16'hFFFF; mdone = 1; end
      end else cnt = cnt - 16'd1;
    end
    if (lc) begin cnt = cv; bcnt = cv; mdone = 0; end
    @(posedge clk); #1;
    check_all(tag);
  endtask

  task automatic adv_n(input string tag, input int n, input bit ai);
    for (int k = 0; k < n; k++) cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, ai);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    for (int m = 0; m < 2; m++) begin ea[m] = 0; boff[m] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R11 reset");

    // R1 R2: page/address composition sweep, including odd low pages
    for (int i = 0; i < 256; i++)
      cyc("R1 R2 compose", 1, 16'(i * 257 + 3), 0, 0, 1, 8'(i), 1, 8'(255 - i), 0, 0);

    // R3: no extension, wrap inside page
    cyc("R3 setup", 1, 16'hFFFD, 1, 16'd20, 1, 8'h35, 0, 0, 0, 0);
    adv_n("R3 wrap", 5, 0);

    // R4: extension on, carry into page
    cyc("R4 setup", 1, 16'hFFFE, 1, 16'd20, 1, 8'hFF, 1, 8'h12, 0, 0);
    adv_n("R4 carry", 4, 0);

    // R5: low page write leaves extended mode
    cyc("R5 lo write", 1, 16'hFFFF, 0, 0, 1, 8'h41, 0, 0, 0, 0);
    adv_n("R5 wrap again", 2, 0);
    cyc("R5 hi write", 1, 16'hFFFF, 0, 0, 0, 0, 1, 8'h07, 0, 0);
    adv_n("R5 carry again", 2, 0);

    // R6 R7 R8: count sweep; tc after N+1 steps, extra advances ignored
    for (int n = 0; n < 24; n++) begin
      cyc("R6 load", 1, 16'(n * 16'h0A3B), 1, 16'(n), 0, 0, 0, 0, 0, 0);
      adv_n("R6 R7 count", n + 1, 0);
      adv_n("R8 frozen", 2, 0);
    end

    // R8: count load clears done
    cyc("R8 reload clears", 0, 0, 1, 16'd2, 0, 0, 0, 0, 0, 0);
    adv_n("R8 runs again", 4, 0);

    // R9: auto-initialise loops
    cyc("R9 setup", 1, 16'h0100, 1, 16'd3, 0, 0, 0, 0, 0, 1);
    adv_n("R9 autoinit", 11, 1);

    // R10: carry and auto-init terminal count together
    cyc("R10 setup", 1, 16'hFFFF, 1, 16'd0, 1, 8'h80, 1, 8'h22, 0, 1);
    adv_n("R10 reload wins", 3, 1);
    cyc("R10 setup2", 1, 16'hFFFF, 1, 16'd0, 0, 0, 0, 0, 0, 0);
    adv_n("R10 no autoinit carries", 2, 0);

    // R12: load with advance in the same cycle
    cyc("R12 base", 1, 16'h2000, 1, 16'd9, 0, 0, 0, 0, 0, 0);
    cyc("R12 addr load blocks", 1, 16'h3000, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R12 cnt load blocks", 0, 0, 1, 16'd5, 0, 0, 0, 0, 1, 0);
    cyc("R12 page load blocks", 0, 0, 0, 0, 1, 8'h09, 0, 0, 1, 0);
    adv_n("R12 after", 3, 0);

    cyc("idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule